// File: doc/BRIEF.md
# Programmable Time-Slot Arbiter

The block shares one resource among up to eight clients by walking a circular wheel of sixteen time slots. Software fills the wheel through two 32-bit table registers. Each slot holds a 4-bit code that names a client, marks the slot as empty, or is a reserved value. The arbiter starts at its current slot and gives the grant to the first slot, in circular order, whose code names a client that is requesting. Empty slots, reserved codes and slots whose client is idle are passed over during that same search.

A grant stays in force until the client signals completion. A third register holds an 8-bit preset for a hold timer, and an active-low enable for it. When that timer is enabled it can end a grant that is held too long. When a grant ends, the search restarts at the slot after the one that won. A waiting client can therefore be granted in the next cycle with no idle cycle between grants. The outputs are a one-hot grant vector and the index of the slot that owns the wheel.

Top module: `slice_wheel_arbiter`

## Requirements
- R1: After reset the grant is all zero and the slot index is 0. Every table nibble holds n mod 8 for slot n. The timer is disabled and its preset is 255.
- R2: A write strobe on the low table register loads slots 0–7 from the write data, and a strobe on the high register loads slots 8–15. Slot n sits at data bits [4*(n mod 8)+3 : 4*(n mod 8)]. The new table takes effect from the next cycle.
- R3: Codes 0–7 name the client of the same request/grant bit index. Code 2 marks an empty slot. Client bit 2 is never granted. Codes 8–15 are reserved, and slots holding them are passed over.
- R4: When no grant is held, the search starts at the current slot and goes in circular order. The first slot whose code names a requesting client wins. One cycle later the grant shows that client and the slot index shows the winning slot.
- R5: If no slot qualifies while no grant is held, the grant stays zero and the slot index does not move.
- R6: A grant, together with its slot index, is held unchanged until done is high in a cycle, unless the timer ends it first. In that cycle the search restarts at the held slot plus one, wrapping from 15 to 0. The next grant appears one cycle later. If nothing qualifies, the grant drops to zero and the slot index becomes the held slot plus one.
- R7: The timer register takes its preset from data bits [7:0] and its disable flag from bit 16, where 0 enables the timer. When enabled, a grant without done lasts exactly preset+1 cycles. It is then released exactly as done would release it. The preset is captured when each grant is issued.
- R8: With the disable flag at 1, a grant without done is held for any number of cycles.
- R9: At most one grant bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_lo | input | 1 | Write strobe for the table register holding slots 0–7 |
| wr_hi | input | 1 | Write strobe for the table register holding slots 8–15 |
| wr_tmo | input | 1 | Write strobe for the timer register |
| wdata | input | 32 | Write data shared by the three registers |
| req | input | 8 | Request vector, one bit per client |
| done | input | 1 | The current grant holder has finished |
| grant | output | 8 | One-hot grant, zero when idle |
| slot_idx | output | 4 | Slot that holds or last held the wheel |

## Verification
The bench walks a wheel with empty slots, reserved codes and repeated clients. It checks the wrap from slot 15 to slot 0. A search that did not skip within one cycle would show a gap or the wrong slot. A search that restarted at the held slot rather than the one after it would grant the same slot again. The bench also requests on client bit 2. A design that decoded the empty code as a client would grant that bit. The timer cases count the cycles of a grant with presets 3 and 0, and a design that is off by one shows the release one cycle early or late. When nothing is requesting, the slot index must not move. A design that advanced it anyway would show the wrong index in the idle checks.

// File: rtl/slarb_pkg.sv
package slarb_pkg;

   // Default geometry of the slot wheel
   localparam int unsigned SLARB_REG_W     = 32;
   localparam int unsigned SLARB_CODE_W    = 4;
   localparam int unsigned SLARB_CLIENTS   = 8;
   localparam int unsigned SLARB_NULL_CODE = 2;
   localparam int unsigned SLARB_TMR_W     = 8;
   localparam int unsigned SLARB_DIS_BIT   = 16;

   // Arbiter phase: waiting for a winner, or a grant is in force
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_HOLD = 1'b1
   } slarb_phase_e;

   // Index width that never collapses to zero bits
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/slarb_cfg_regs.sv
module slarb_cfg_regs #(
   parameter int unsigned REG_W      = 32,
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned TMR_W      = 8,
   parameter int unsigned DIS_BIT    = 16,
   parameter logic [REG_W-1:0] RST_LO = 32'h7654_3210,
   parameter logic [REG_W-1:0] RST_HI = 32'h7654_3210,
   parameter logic [TMR_W-1:0] RST_PRESET = '1,
   parameter bit RST_DIS = 1'b1,
   localparam int unsigned SLOTS_PER_REG = REG_W / CODE_W,
   localparam int unsigned NUM_SLOTS     = 2 * SLOTS_PER_REG
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_lo,
   input  logic                          wr_hi,
   input  logic                          wr_tmo,
   input  logic [REG_W-1:0]              wdata,
   output logic [NUM_SLOTS*CODE_W-1:0]   slot_codes,
   output logic [TMR_W-1:0]              preset,
   output logic                          tmr_dis
);

   logic [REG_W-1:0] tbl_lo_q;
   logic [REG_W-1:0] tbl_hi_q;
   logic [TMR_W-1:0] preset_q;
   logic             dis_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_lo_q <= RST_LO;
         tbl_hi_q <= RST_HI;
      end else begin
         if (wr_lo) tbl_lo_q <= wdata;
         if (wr_hi) tbl_hi_q <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         preset_q <= RST_PRESET;
         dis_q    <= RST_DIS;
      end else if (wr_tmo) begin
         preset_q <= wdata[TMR_W-1:0];
         dis_q    <= wdata[DIS_BIT];
      end
   end

   // Flatten both registers into one slot-ordered vector
   for (genvar s = 0; s < SLOTS_PER_REG; s++) begin : g_lo
      assign slot_codes[s*CODE_W +: CODE_W] = tbl_lo_q[s*CODE_W +: CODE_W];
   end
   for (genvar s = 0; s < SLOTS_PER_REG; s++) begin : g_hi
      assign slot_codes[(s+SLOTS_PER_REG)*CODE_W +: CODE_W] = tbl_hi_q[s*CODE_W +: CODE_W];
   end

   assign preset  = preset_q;
   assign tmr_dis = dis_q;

endmodule

// File: rtl/slarb_slot_search.sv
module slarb_slot_search
   import slarb_pkg::*;
#(
   parameter int unsigned NUM_SLOTS   = 16,
   parameter int unsigned CODE_W      = 4,
   parameter int unsigned NUM_CLIENTS = 8,
   parameter int unsigned NULL_CODE   = 2,
   localparam int unsigned SLOT_W = idx_w(NUM_SLOTS),
   localparam int unsigned CLI_W  = idx_w(NUM_CLIENTS)
) (
   input  logic [NUM_SLOTS*CODE_W-1:0] slot_codes,
   input  logic [NUM_CLIENTS-1:0]      req,
   input  logic [SLOT_W-1:0]           base,
   output logic                        found,
   output logic [SLOT_W-1:0]           win_slot,
   output logic [CLI_W-1:0]            win_client
);

   // Per-slot qualification, independent of the starting point
   logic [NUM_SLOTS-1:0]  slot_hit;
   logic [CLI_W-1:0]      slot_cli [NUM_SLOTS];

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [CODE_W-1:0] code;
      assign code = slot_codes[s*CODE_W +: CODE_W];
      always_comb begin
         slot_hit[s] = 1'b0;
         slot_cli[s] = '0;
         for (int c = 0; c < NUM_CLIENTS; c++) begin
            if (code == CODE_W'(c) && c != NULL_CODE) begin
               slot_hit[s] = req[c];
               slot_cli[s] = CLI_W'(c);
            end
         end
      end
   end

   // Circular scan from base; the nearest qualifying slot wins
   always_comb begin
      found      = 1'b0;
      win_slot   = base;
      win_client = '0;
      for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
         logic [SLOT_W-1:0] idx;
         idx = base + SLOT_W'(i);
         if (slot_hit[idx]) begin
            found      = 1'b1;
            win_slot   = idx;
            win_client = slot_cli[idx];
         end
      end
   end

endmodule

// File: rtl/slarb_hold_timer.sv
module slarb_hold_timer #(
   parameter int unsigned TMR_W    = 8,
   parameter bit          TIMER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             holding,
   input  logic [TMR_W-1:0] preset,
   input  logic             tmr_dis,
   output logic             expired
);

   if (TIMER_EN) begin : g_timer
      logic [TMR_W-1:0] cnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (load) begin
            cnt_q <= preset;
         end else if (holding && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign expired = holding && !tmr_dis && (cnt_q == '0);
   end else begin : g_no_timer
      logic unused_in;
      assign unused_in = ^{clk, rst_n, load, holding, preset, tmr_dis};
      assign expired   = 1'b0;
   end

endmodule

// File: rtl/slice_wheel_arbiter.sv
module slice_wheel_arbiter
   import slarb_pkg::*;
#(
   parameter int unsigned REG_W       = SLARB_REG_W,
   parameter int unsigned CODE_W      = SLARB_CODE_W,
   parameter int unsigned NUM_CLIENTS = SLARB_CLIENTS,
   parameter int unsigned NULL_CODE   = SLARB_NULL_CODE,
   parameter int unsigned TMR_W       = SLARB_TMR_W,
   parameter int unsigned DIS_BIT     = SLARB_DIS_BIT,
   parameter bit          TIMER_EN    = 1'b1,
   parameter logic [REG_W-1:0] RST_LO = 32'h7654_3210,
   parameter logic [REG_W-1:0] RST_HI = 32'h7654_3210,
   localparam int unsigned SLOTS_PER_REG = REG_W / CODE_W,
   localparam int unsigned NUM_SLOTS     = 2 * SLOTS_PER_REG,
   localparam int unsigned SLOT_W        = idx_w(NUM_SLOTS),
   localparam int unsigned CLI_W         = idx_w(NUM_CLIENTS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_lo,
   input  logic                   wr_hi,
   input  logic                   wr_tmo,
   input  logic [REG_W-1:0]       wdata,
   input  logic [NUM_CLIENTS-1:0] req,
   input  logic                   done,
   output logic [NUM_CLIENTS-1:0] grant,
   output logic [SLOT_W-1:0]      slot_idx
);

   // Elaboration-time parameter checks
   if (REG_W % CODE_W != 0) begin : g_chk_pack
      $error("table register width must hold a whole number of slot codes");
   end
   if (NUM_CLIENTS > (1 << CODE_W)) begin : g_chk_codes
      $error("slot code too narrow to name every client");
   end
   if (NULL_CODE >= NUM_CLIENTS) begin : g_chk_null
      $error("empty-slot code must lie inside the client code range");
   end
   if (DIS_BIT >= REG_W || TMR_W > DIS_BIT) begin : g_chk_tmr
      $error("timer fields overlap or exceed the register width");
   end
   if ((1 << SLOT_W) != NUM_SLOTS) begin : g_chk_pow2
      $error("slot count must be a power of two for pointer wrap");
   end

   logic [NUM_SLOTS*CODE_W-1:0] slot_codes;
   logic [TMR_W-1:0]            preset;
   logic                        tmr_dis;

   slarb_cfg_regs #(
      .REG_W     (REG_W),
      .CODE_W    (CODE_W),
      .TMR_W     (TMR_W),
      .DIS_BIT   (DIS_BIT),
      .RST_LO    (RST_LO),
      .RST_HI    (RST_HI),
      .RST_PRESET('1),
      .RST_DIS   (1'b1)
   ) i_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (wr_lo),
      .wr_hi     (wr_hi),
      .wr_tmo    (wr_tmo),
      .wdata     (wdata),
      .slot_codes(slot_codes),
      .preset    (preset),
      .tmr_dis   (tmr_dis)
   );

   slarb_phase_e           phase_q;
   logic [SLOT_W-1:0]      ptr_q;
   logic [NUM_CLIENTS-1:0] grant_q;
   logic                   expired;
   logic                   release_now;
   logic                   evaluate;
   logic [SLOT_W-1:0]      base;
   logic                   found;
   logic [SLOT_W-1:0]      win_slot;
   logic [CLI_W-1:0]       win_client;
   logic                   take;

   assign release_now = (phase_q == PH_HOLD) && (done || expired);
   assign evaluate    = (phase_q == PH_IDLE) || release_now;
   assign base        = release_now ? ptr_q + 1'b1 : ptr_q;
   assign take        = evaluate && found;

   slarb_slot_search #(
      .NUM_SLOTS  (NUM_SLOTS),
      .CODE_W     (CODE_W),
      .NUM_CLIENTS(NUM_CLIENTS),
      .NULL_CODE  (NULL_CODE)
   ) i_search (
      .slot_codes(slot_codes),
      .req       (req),
      .base      (base),
      .found     (found),
      .win_slot  (win_slot),
      .win_client(win_client)
   );

   slarb_hold_timer #(
      .TMR_W   (TMR_W),
      .TIMER_EN(TIMER_EN)
   ) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (take),
      .holding(phase_q == PH_HOLD),
      .preset (preset),
      .tmr_dis(tmr_dis),
      .expired(expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         ptr_q   <= '0;
         grant_q <= '0;
      end else if (take) begin
         phase_q <= PH_HOLD;
         ptr_q   <= win_slot;
         grant_q <= NUM_CLIENTS'(1) << win_client;
      end else if (release_now) begin
         phase_q <= PH_IDLE;
         ptr_q   <= ptr_q + 1'b1;
         grant_q <= '0;
      end
   end

   assign grant    = grant_q;
   assign slot_idx = ptr_q;

endmodule

// File: rtl/slarb_checker.sv
module slarb_checker #(
   parameter int unsigned NUM_CLIENTS = 8,
   parameter int unsigned SLOT_W      = 4,
   parameter int unsigned NULL_CODE   = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_CLIENTS-1:0] req,
   input logic                   done,
   input logic [NUM_CLIENTS-1:0] grant,
   input logic [SLOT_W-1:0]      slot_idx,
   input logic                   tmr_dis
);

   a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   a_r3_empty_code_never_granted: assert property (@(posedge clk) disable iff (!rst_n)
      !grant[NULL_CODE]);

   a_r5_idle_no_move: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0 && grant == '0) |=> (grant == '0 && $stable(slot_idx)));

   a_r4_new_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && grant != $past(grant)) |-> ((grant & $past(req)) != '0));

   a_r6_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0 && !done && tmr_dis) |=> (grant == $past(grant) && slot_idx == $past(slot_idx)));

endmodule

bind slice_wheel_arbiter slarb_checker #(
   .NUM_CLIENTS(NUM_CLIENTS),
   .SLOT_W     (SLOT_W),
   .NULL_CODE  (NULL_CODE)
) i_slarb_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .req     (req),
   .done    (done),
   .grant   (grant),
   .slot_idx(slot_idx),
   .tmr_dis (tmr_dis)
);

// File: tb/test_slice_wheel_arbiter.sv
`timescale 1ns/1ps
module test_slice_wheel_arbiter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_lo = 1'b0, wr_hi = 1'b0, wr_tmo = 1'b0;
   logic [31:0] wdata = '0;
   logic [7:0]  req = '0;
   logic        done = 1'b0;
   logic [7:0]  grant;
   logic [3:0]  slot_idx;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   slice_wheel_arbiter i_slice_wheel_arbiter (
      .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_tmo(wr_tmo),
      .wdata(wdata), .req(req), .done(done), .grant(grant), .slot_idx(slot_idx)
   );

   // Row: req[20:13] done[12] exp_grant[11:4] exp_slot[3:0]
   // Wheel: slots 0..7 = 0,1,3,4,5,6,7,empty ; 8..15 = rsv,3,empty,0,rsv,5,empty,1
   localparam logic [20:0] VEC [15] = '{
      {8'h00, 1'b0, 8'h00, 4'd0},   // R5 nothing requests
      {8'h08, 1'b0, 8'h08, 4'd2},   // R4 skip slots 0,1
      {8'h08, 1'b0, 8'h08, 4'd2},   // R6 held
      {8'h09, 1'b1, 8'h08, 4'd9},   // R6 restart at 3, pass empty and reserved
      {8'h01, 1'b1, 8'h01, 4'd11},  // R6 back-to-back
      {8'h00, 1'b1, 8'h00, 4'd12},  // R6 no winner, pointer +1
      {8'h00, 1'b0, 8'h00, 4'd12},  // R5 pointer still
      {8'h02, 1'b0, 8'h02, 4'd15},  // R3 reserved slot 12 skipped
      {8'h03, 1'b1, 8'h01, 4'd0},   // R6 wrap 15 to 0
      {8'h80, 1'b1, 8'h80, 4'd6},   // R4
      {8'h04, 1'b1, 8'h00, 4'd7},   // R3 empty code never grants client 2
      {8'h04, 1'b0, 8'h00, 4'd7},   // R3
      {8'h20, 1'b0, 8'h20, 4'd13},  // R4 long circular skip
      {8'h20, 1'b1, 8'h20, 4'd4},   // R6 same client, next slot via wrap
      {8'h00, 1'b1, 8'h00, 4'd5}    // R6
   };

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input logic [7:0] g_act, input logic [7:0] g_exp,
                      input logic [3:0] s_act, input logic [3:0] s_exp);
      total++;
      if (g_act !== g_exp || s_act !== s_exp) begin
         bad++;
         $display("FAIL %s: grant=%02h slot=%0d expected grant=%02h slot=%0d",
                  tag, g_act, s_act, g_exp, s_exp);
      end
   endtask

   task automatic wr(input int which, input logic [31:0] d);
      wdata = d;
      wr_lo = (which == 0);
      wr_hi = (which == 1);
      wr_tmo = (which == 2);
      step();
      wr_lo = 1'b0; wr_hi = 1'b0; wr_tmo = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      bad++; total++;
      $display("FAIL watchdog: run did not end, expected end before limit");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      chk("R1 reset state", grant, 8'h00, slot_idx, 4'd0);

      // R2 program both halves of the wheel
      wr(0, 32'h2765_4310);
      wr(1, 32'h125F_0239);
      wr(2, 32'h0001_0000);   // timer disabled
      chk("R2 idle after writes", grant, 8'h00, slot_idx, 4'd0);

      for (int i = 0; i < 15; i++) begin
         req  = VEC[i][20:13];
         done = VEC[i][12];
         step();
         chk($sformatf("R4/R6 vector %0d", i), grant, VEC[i][11:4], slot_idx, VEC[i][3:0]);
      end
      req = '0; done = 1'b0;

      // R7 timer preset 3, enabled
      wr(2, 32'h0000_0003);
      chk("R7 write idle", grant, 8'h00, slot_idx, 4'd5);
      req = 8'h50;
      step();
      chk("R7 grant issued", grant, 8'h40, slot_idx, 4'd5);
      for (int i = 0; i < 3; i++) begin
         step();
         chk("R7 within preset+1", grant, 8'h40, slot_idx, 4'd5);
      end
      step();
      chk("R7 expiry moves on", grant, 8'h10, slot_idx, 4'd3);

      // R8 disabled timer holds
      wr(2, 32'h0001_0000);
      chk("R8 write while held", grant, 8'h10, slot_idx, 4'd3);
      repeat (20) step();
      chk("R8 long hold", grant, 8'h10, slot_idx, 4'd3);
      done = 1'b1;
      step();
      done = 1'b0;
      chk("R6 done releases", grant, 8'h40, slot_idx, 4'd5);

      // R7 preset 0 captured at grant, enable takes effect after write
      req = '0;
      wr(2, 32'h0000_0000);
      chk("R7 enable write cycle", grant, 8'h40, slot_idx, 4'd5);
      step();
      chk("R7 preset zero expiry", grant, 8'h00, slot_idx, 4'd6);

      // R1 mid-run reset restores defaults
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      chk("R1 reset outputs", grant, 8'h00, slot_idx, 4'd0);
      req = 8'h80;
      step();
      chk("R1 default table", grant, 8'h80, slot_idx, 4'd7);
      repeat (300) step();
      chk("R1 default timer disabled", grant, 8'h80, slot_idx, 4'd7);

      // R2 high register nibble 0 is slot 8
      wr(1, 32'h2222_2227);
      chk("R2 write while held", grant, 8'h80, slot_idx, 4'd7);
      done = 1'b1;
      step();
      done = 1'b0;
      chk("R2 slot 8 from high register", grant, 8'h80, slot_idx, 4'd8);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule